// File: doc/BRIEF.md
# Display Integrity Checker Control and Status Unit

This unit holds the register state around a per-region signature checker for a display stream. Software reaches it through a plain synchronous word-addressed write and read port. It sets the global check enable and the enable for the mismatch pin. For each region it holds the enable, a one-way lock, the two corner coordinates and a reference signature. It also holds an interrupt mask word that can be frozen until reset, and a status word. The status word carries a results-ready flag, one mismatch flag per region and a derived error flag.

The checker datapath sends the unit two kinds of single-cycle pulse: results-ready, and a mismatch pulse per region. The unit records them as sticky flags, which software clears by writing 1 to the flag's bit. It combines the flags with the masks into one interrupt line. It also drives a status pin whose toggle rate shows whether any mismatch is pending. Each region's enable and reference value are exported to the datapath.

Top module: `icc_ctrl`

## Requirements
- R1: After reset every register reads zero except the interrupt mask word, which reads 3 (both interrupts masked). The interrupt output and the status pin are low.
- R2: Address map (word addresses): 0 control (bit0 check-on, bit1 pin-enable), 1 interrupt mask, 2 status, 3 reads zero. Region i occupies 4+4i .. 7+4i: control (bit0 enable, bit1 lock), upper-left corner, lower-right corner, reference. Unmapped addresses read zero and ignore writes. The read data appears on the cycle after a read is requested.
- R3: While check-on is set, a results-ready pulse sets status bit0, and a mismatch pulse for region i sets status bit 2+i if that region is enabled. A set in the same cycle as a write-1-to-clear of the same bit leaves the bit set.
- R4: Writing 1 to status bit0 or to bit 2+i clears that flag. Status bit1 (error) reads as the OR of all region flags, ignores writes, and drops only when the last set region flag is cleared.
- R5: Mask word bit0 masks the ready interrupt and bit1 masks the error interrupt; 1 means masked. Bit2 is a freeze bit that stays set until reset. Once it is set, writes to the mask word are ignored.
- R6: Once a region's lock bit is set, writes to that region's control word and coordinates are ignored until reset.
- R7: Coordinate words keep x in bits 12:0 and y in bits 27:16, and the other bits read zero. A coordinate write takes effect only while the region is disabled and unlocked.
- R8: The interrupt output is (ready and not ready-mask) or (error and not error-mask).
- R9: While check-on and pin-enable are both set, the pin toggles every 8 clocks (period 16) when the error flag is set, and every 2 clocks (period 4) otherwise. When either enable is clear, the pin is held low.
- R10: A reference value write always takes effect, including while the region is enabled or locked. Each region's reference value and enable drive the exported outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| ready_pulse | input | 1 | Results-ready event from checker |
| mismatch_pulse | input | NREG | Per-region mismatch events |
| chk_enable | output | 1 | Global check enable |
| roi_en | output | NREG | Per-region enable |
| roi_ref | output | NREG*32 | Per-region reference signatures |
| irq | output | 1 | Interrupt request |
| ext_pin | output | 1 | Mismatch indication pin |

## Verification
Two events can land in the same cycle: a software write-1-to-clear of a status bit and a checker pulse that sets the same bit. The second pairing is a lock or freeze write in the same cycle as other writes to the guarded fields. The bench provokes both on purpose in directed steps, and it produces them often during a long random phase of writes, reads and pulses. An independent register model decides each case: a set wins over a clear, and a guarded field keeps its old value. Every readback and every cycle of the interrupt output is compared against that model.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int DW        = 32;
  localparam int XW        = 13;
  localparam int YW        = 12;
  localparam int YLSB      = 16;
  localparam int GLB_WORDS = 4;
  localparam int RGN_WORDS = 4;
  localparam int SLOW_DIV  = 16;
  localparam int FAST_DIV  = 4;
  localparam int CNTW      = $clog2(SLOW_DIV / 2);

  localparam logic [DW-1:0] COORD_MASK =
    DW'((64'd1 << XW) - 1) | (DW'((64'd1 << YW) - 1) << YLSB);

  typedef enum logic [1:0] {
    GW_CTRL = 2'd0,
    GW_MASK = 2'd1,
    GW_STAT = 2'd2,
    GW_RSVD = 2'd3
  } glb_word_e;

  typedef enum logic [1:0] {
    RW_CTL = 2'd0,
    RW_UL  = 2'd1,
    RW_LR  = 2'd2,
    RW_REF = 2'd3
  } rgn_word_e;

  function automatic logic [DW-1:0] pack_coord(input logic [DW-1:0] w);
    return w & COORD_MASK;
  endfunction

  function automatic logic [CNTW-1:0] toggle_limit(input logic slow);
    return slow ? CNTW'(SLOW_DIV / 2 - 1) : CNTW'(FAST_DIV / 2 - 1);
  endfunction

  function automatic logic flag_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/icc_region.sv
module icc_region
  import icc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [1:0]    word,
  input  logic [DW-1:0] wdata,
  output logic          en,
  output logic          lock,
  output logic [DW-1:0] ul,
  output logic [DW-1:0] lr,
  output logic [DW-1:0] refv
);
  logic ctl_open;
  logic coord_open;

  assign ctl_open   = ~lock;
  assign coord_open = ~lock & ~en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      lock <= 1'b0;
      ul   <= '0;
      lr   <= '0;
      refv <= '0;
    end else if (sel_wr) begin
      case (rgn_word_e'(word))
        RW_CTL: if (ctl_open) begin
          en   <= wdata[0];
          lock <= wdata[1];
        end
        RW_UL:  if (coord_open) ul <= pack_coord(wdata);
        RW_LR:  if (coord_open) lr <= pack_coord(wdata);
        default: refv <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/icc_flags.sv
module icc_flags
  import icc_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_ready,
  input  logic [NREG-1:0] set_mm,
  input  logic            clr_ready,
  input  logic [NREG-1:0] clr_mm,
  output logic            ready,
  output logic [NREG-1:0] mm,
  output logic            err
);
  always_ff @(posedge clk) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= flag_next(ready, clr_ready, set_ready);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) mm[i] <= 1'b0;
      else        mm[i] <= flag_next(mm[i], clr_mm[i], set_mm[i]);
    end
  end

  assign err = |mm;
endmodule

// File: rtl/icc_pin.sv
module icc_pin
  import icc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic slow,
  output logic pin
);
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] limit;
  logic            hit;

  assign limit = toggle_limit(slow);
  assign hit   = cnt >= limit;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt <= '0;
      pin <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      pin <= ~pin;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter  int NREG = 4,
  localparam int AW   = $clog2(GLB_WORDS + RGN_WORDS * NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic               ready_pulse,
  input  logic [NREG-1:0]    mismatch_pulse,
  output logic               chk_enable,
  output logic [NREG-1:0]    roi_en,
  output logic [NREG*DW-1:0] roi_ref,
  output logic               irq,
  output logic               ext_pin
);
  localparam int PW = AW - 2;

  logic ctrl_on, ext_en, fmask, emask, freeze;
  logic glb_sel, wr_ctrl, wr_mask, wr_stat;
  logic [NREG-1:0] rsel;
  logic [NREG-1:0] rg_en, rg_lock;
  logic [NREG-1:0][DW-1:0] rg_ul, rg_lr, rg_ref;
  logic set_ready, clr_ready;
  logic [NREG-1:0] set_mm, clr_mm;
  logic st_ready, st_err;
  logic [NREG-1:0] st_mm;
  logic [DW-1:0] rd_word;

  assign glb_sel = addr[AW-1:2] == '0;
  assign wr_ctrl = wr_en & glb_sel & (glb_word_e'(addr[1:0]) == GW_CTRL);
  assign wr_mask = wr_en & glb_sel & (glb_word_e'(addr[1:0]) == GW_MASK);
  assign wr_stat = wr_en & glb_sel & (glb_word_e'(addr[1:0]) == GW_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_on <= 1'b0;
      ext_en  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_on <= wdata[0];
      ext_en  <= wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmask  <= 1'b1;
      emask  <= 1'b1;
      freeze <= 1'b0;
    end else if (wr_mask && !freeze) begin
      fmask  <= wdata[0];
      emask  <= wdata[1];
      freeze <= wdata[2];
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_rgn
    assign rsel[i] = addr[AW-1:2] == PW'(i + 1);
    icc_region u_rgn (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_wr(wr_en & rsel[i]),
      .word  (addr[1:0]),
      .wdata (wdata),
      .en    (rg_en[i]),
      .lock  (rg_lock[i]),
      .ul    (rg_ul[i]),
      .lr    (rg_lr[i]),
      .refv  (rg_ref[i])
    );
    assign roi_ref[i*DW +: DW] = rg_ref[i];
  end

  assign set_ready = ready_pulse & ctrl_on;
  assign set_mm    = mismatch_pulse & rg_en & {NREG{ctrl_on}};
  assign clr_ready = wr_stat & wdata[0];
  assign clr_mm    = {NREG{wr_stat}} & wdata[2 +: NREG];

  icc_flags #(.NREG(NREG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ready(set_ready),
    .set_mm   (set_mm),
    .clr_ready(clr_ready),
    .clr_mm   (clr_mm),
    .ready    (st_ready),
    .mm       (st_mm),
    .err      (st_err)
  );

  icc_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .active(ctrl_on & ext_en),
    .slow  (st_err),
    .pin   (ext_pin)
  );

  always_comb begin
    rd_word = '0;
    if (glb_sel) begin
      case (glb_word_e'(addr[1:0]))
        GW_CTRL: rd_word[1:0] = {ext_en, ctrl_on};
        GW_MASK: rd_word[2:0] = {freeze, emask, fmask};
        GW_STAT: begin
          rd_word[0]         = st_ready;
          rd_word[1]         = st_err;
          rd_word[2 +: NREG] = st_mm;
        end
        default: rd_word = '0;
      endcase
    end
    for (int i = 0; i < NREG; i++) begin
      if (rsel[i]) begin
        case (rgn_word_e'(addr[1:0]))
          RW_CTL:  rd_word[1:0] = {rg_lock[i], rg_en[i]};
          RW_UL:   rd_word = rg_ul[i];
          RW_LR:   rd_word = rg_lr[i];
          default: rd_word = rg_ref[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign chk_enable = ctrl_on;
  assign roi_en     = rg_en;
  assign irq        = (st_ready & ~fmask) | (st_err & ~emask);
endmodule

// File: rtl/icc_ctrl_chk.sv
module icc_ctrl_chk
  import icc_pkg::*;
#(
  parameter int NREG = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ctrl_on,
  input logic                    fmask,
  input logic                    emask,
  input logic                    freeze,
  input logic                    st_ready,
  input logic                    st_err,
  input logic [NREG-1:0]         st_mm,
  input logic                    ready_pulse,
  input logic [NREG-1:0]         mismatch_pulse,
  input logic [NREG-1:0]         rg_en,
  input logic [NREG-1:0]         rg_lock,
  input logic [NREG-1:0][DW-1:0] rg_ul,
  input logic [NREG-1:0][DW-1:0] rg_lr,
  input logic                    irq,
  input logic                    ext_pin
);
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_on && ready_pulse) |=> st_ready); // R3

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (freeze && $stable(fmask) && $stable(emask))); // R5

  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !emask) |-> irq); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((!st_ready || fmask) && (!st_err || emask)) |-> !irq); // R8

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_on |=> !ext_pin); // R9

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    AST_MM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_on && rg_en[i] && mismatch_pulse[i]) |=> st_mm[i]); // R3

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rg_lock[i] |=> (rg_lock[i] && $stable(rg_en[i]))); // R6

    AST_COORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rg_en[i] || rg_lock[i]) |=> ($stable(rg_ul[i]) && $stable(rg_lr[i]))); // R7
  end
endmodule

bind icc_ctrl icc_ctrl_chk #(.NREG(NREG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_on       (ctrl_on),
  .fmask         (fmask),
  .emask         (emask),
  .freeze        (freeze),
  .st_ready      (st_ready),
  .st_err        (st_err),
  .st_mm         (st_mm),
  .ready_pulse   (ready_pulse),
  .mismatch_pulse(mismatch_pulse),
  .rg_en         (rg_en),
  .rg_lock       (rg_lock),
  .rg_ul         (rg_ul),
  .rg_lr         (rg_lr),
  .irq           (irq),
  .ext_pin       (ext_pin)
);

// File: tb/tb_icc_ctrl.sv
`timescale 1ns/1ps
module tb_icc_ctrl;
  localparam int NR = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ready_pulse = 1'b0;
  logic [NR-1:0] mismatch_pulse = '0;
  logic chk_enable, irq, ext_pin;
  logic [NR-1:0] roi_en;
  logic [NR*32-1:0] roi_ref;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench register model
  logic m_on, m_ext, m_fm, m_em, m_frz, m_rdy;
  logic [NR-1:0] m_mm, m_en, m_lk;
  logic [31:0] m_ul [NR];
  logic [31:0] m_lr [NR];
  logic [31:0] m_ref [NR];

  always #2.5 clk = ~clk;

  icc_ctrl #(.NREG(NR)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready_pulse(ready_pulse),
    .mismatch_pulse(mismatch_pulse), .chk_enable(chk_enable), .roi_en(roi_en),
    .roi_ref(roi_ref), .irq(irq), .ext_pin(ext_pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] coord(input logic [31:0] w);
    logic [31:0] r;
    r = '0;
    r[12:0]  = w[12:0];
    r[27:16] = w[27:16];
    return r;
  endfunction

  function automatic logic m_irq();
    return (m_rdy && !m_fm) || ((|m_mm) && !m_em);
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    logic [31:0] r;
    int k;
    r = '0;
    if (a == 0) r[1:0] = {m_ext, m_on};
    else if (a == 1) r[2:0] = {m_frz, m_em, m_fm};
    else if (a == 2) begin
      r[0] = m_rdy;
      r[1] = |m_mm;
      r[2 +: NR] = m_mm;
    end else if (a >= 4 && a < 4 + 4 * NR) begin
      k = int'(a) / 4 - 1;
      case (a % 4)
        0: r[1:0] = {m_lk[k], m_en[k]};
        1: r = m_ul[k];
        2: r = m_lr[k];
        default: r = m_ref[k];
      endcase
    end
    return r;
  endfunction

  task automatic m_reset();
    m_on = 0; m_ext = 0; m_fm = 1; m_em = 1; m_frz = 0; m_rdy = 0;
    m_mm = '0; m_en = '0; m_lk = '0;
    for (int i = 0; i < NR; i++) begin
      m_ul[i] = '0; m_lr[i] = '0; m_ref[i] = '0;
    end
  endtask

  task automatic m_update(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic rp, input logic [NR-1:0] mp);
    logic o_on;
    logic [NR-1:0] o_en, clr;
    logic clr_r;
    int k;
    o_on = m_on; o_en = m_en; clr = '0; clr_r = 0;
    if (w) begin
      if (a == 0) begin m_on = d[0]; m_ext = d[1]; end
      else if (a == 1) begin
        if (!m_frz) begin m_fm = d[0]; m_em = d[1]; m_frz = d[2]; end
      end else if (a == 2) begin
        clr_r = d[0]; clr = d[2 +: NR];
      end else if (a >= 4 && a < 4 + 4 * NR) begin
        k = int'(a) / 4 - 1;
        case (a % 4)
          0: if (!m_lk[k]) begin m_en[k] = d[0]; m_lk[k] = d[1]; end
          1: if (!m_lk[k] && !m_en[k]) m_ul[k] = coord(d);
          2: if (!m_lk[k] && !m_en[k]) m_lr[k] = coord(d);
          default: m_ref[k] = d;
        endcase
      end
    end
    m_rdy = (m_rdy & ~clr_r) | (rp & o_on);
    m_mm  = (m_mm & ~clr) | (mp & o_en & {NR{o_on}});
  endtask

  // one bus cycle; compares read data, irq and exported state
  task automatic step(input string req, input logic w, input logic r, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic rp, input logic [NR-1:0] mp);
    logic [31:0] exp_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; ready_pulse = rp; mismatch_pulse = mp;
    exp_rd = m_read(a);
    @(posedge clk);
    m_update(w, a, d, rp, mp);
    #1;
    if (r) check(req, rdata, exp_rd);
    check("R8 irq", {31'b0, irq}, {31'b0, m_irq()});
    check("R10 exports", {27'b0, chk_enable, roi_en}, {27'b0, m_on, m_en});
    for (int i = 0; i < NR; i++) check("R10 ref out", roi_ref[i*32 +: 32], m_ref[i]);
    wr_en = 0; rd_en = 0; ready_pulse = 0; mismatch_pulse = '0;
  endtask

  task automatic wr(input string req, input logic [AW-1:0] a, input logic [31:0] d);
    step(req, 1'b1, 1'b0, a, d, 1'b0, '0);
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a);
    step(req, 1'b0, 1'b1, a, 32'h0, 1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0; ready_pulse = 0; mismatch_pulse = '0;
    repeat (3) @(posedge clk);
    m_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  // measures spacing of pin toggles against an expected half period
  task automatic pin_rate(input string req, input int half);
    logic last;
    int since, seen;
    repeat (20) @(negedge clk);
    last = ext_pin; since = 0; seen = 0;
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      since++;
      if (ext_pin !== last) begin
        if (seen > 0) check(req, since, half);
        seen++; since = 0; last = ext_pin;
      end
    end
    check({req, " toggles seen"}, {31'b0, seen > 2}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [31:0] d;
    m_reset();
    do_reset();

    // R1 reset values
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 pin", {31'b0, ext_pin}, 32'd0);
    for (int i = 0; i < 4 + 4 * NR; i++) rd("R1 reset readback", AW'(i));
    check("R1 mask model", m_read(1), 32'd3);

    // R2 map and unmapped addresses
    wr("R2", 0, 32'hFFFF_FFFD);
    rd("R2 control", 0);
    wr("R2 unmapped", 5'd25, 32'hFFFF_FFFF);
    rd("R2 unmapped", 5'd25);
    rd("R2 reserved", 3);

    // R7 coordinates while disabled, then blocked while enabled
    wr("R7", 5'd5, 32'hFFFF_FFFF);
    rd("R7 packed coords", 5'd5);
    wr("R7", 5'd6, 32'h0123_4567);
    wr("R7", 5'd4, 32'h1);
    wr("R7 blocked", 5'd5, 32'h0000_0001);
    rd("R7 enabled hold", 5'd5);
    wr("R7", 5'd4, 32'h0);
    wr("R7", 5'd5, 32'h0000_0001);
    rd("R7 reopened", 5'd5);

    // R3 / R4: flag set against same-cycle clear
    wr("R3", 0, 32'h1);
    wr("R3", 5'd8, 32'h1);
    step("R3 set wins", 1'b1, 1'b0, 2, 32'h0000_0008, 1'b0, 4'b0010);
    rd("R3 status after race", 2);
    step("R3 disabled region", 1'b0, 1'b0, 0, 0, 1'b1, 4'b0001);
    rd("R3 region0 off", 2);
    wr("R4", 5'd4, 32'h1);
    step("R3 region0", 1'b0, 1'b0, 0, 0, 1'b0, 4'b0001);
    wr("R4 err not writable", 2, 32'h0000_0002);
    rd("R4 err held", 2);
    wr("R4 clear one", 2, 32'h0000_0004);
    rd("R4 err still set", 2);
    wr("R4 clear last", 2, 32'h0000_0009);
    rd("R4 err dropped", 2);

    // R5 / R8 masks and freeze
    step("R8 ready", 1'b0, 1'b0, 0, 0, 1'b1, '0);
    wr("R8 unmask ready", 1, 32'h2);
    step("R8 mismatch", 1'b0, 1'b0, 0, 0, 1'b0, 4'b0010);
    wr("R8 unmask err", 1, 32'h1);
    wr("R5 freeze", 1, 32'h4);
    wr("R5 frozen write", 1, 32'h3);
    rd("R5 frozen", 1);
    wr("R8 clear ready", 2, 32'h1);
    wr("R8 clear err", 2, 32'h8);

    // R6 / R10 lock
    wr("R6 lock", 5'd12, 32'h3);
    wr("R6 unlock try", 5'd12, 32'h0);
    rd("R6 ctl held", 5'd12);
    wr("R6 coord try", 5'd13, 32'h0000_0abc);
    rd("R6 coord held", 5'd13);
    wr("R10 ref locked", 5'd15, 32'hDEAD_BEEF);
    rd("R10 ref", 5'd15);
    wr("R10 ref enabled", 5'd11, 32'h1234_5678);
    rd("R10 ref", 5'd11);

    // R9 pin
    do_reset();
    wr("R9", 0, 32'h3);
    pin_rate("R9 fast", 2);
    wr("R9", 5'd4, 32'h1);
    step("R9 err", 1'b0, 1'b0, 0, 0, 1'b0, 4'b0001);
    pin_rate("R9 slow", 8);
    wr("R9", 0, 32'h1);
    repeat (2) @(negedge clk);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check("R9 idle ext off", {31'b0, ext_pin}, 32'd0);
    end
    wr("R9", 0, 32'h2);
    repeat (2) @(negedge clk);
    check("R9 idle check off", {31'b0, ext_pin}, 32'd0);

    // random phase
    do_reset();
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      a = AW'($urandom % 22);
      d = $urandom;
      if ($urandom % 12 != 0) begin
        if (a == 1) d[2] = 1'b0;
        if (a >= 4 && a % 4 == 0) d[1] = 1'b0;
      end
      if (a == 0 && ($urandom % 4 != 0)) d[0] = 1'b1;
      step("R2 random read", 1'($urandom % 2), 1'($urandom % 2), a, d,
           1'($urandom % 5 == 0), NR'($urandom % 16 & $urandom % 16));
    end
    for (int i = 0; i < 4 + 4 * NR; i++) rd("R2 final readback", AW'(i));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule